// File: doc/BRIEF.md
# Capability Fault Cause Prioritizer

This unit sits in the execute stage of a RISC-V core with capability extensions. Each cycle it may receive one operation. The operation carries:

- its class: capability-width load or store, jump-and-link, register jump, seal or unseal, or special-register access;
- the effective address;
- the decoded bounds of the authorizing capability, and of the second operand;
- a pending permission cause from upstream, plus store-local, alignment and system-register-permission flags;
- an illegal special-register flag, the index of the register that names the faulting capability, and the debug-mode flag.

From these the unit checks the bounds and picks the single fault that wins under a fixed order for each class. It then presents a verdict one cycle later. The verdict holds a valid flag, a fault flag, an exception cause, a 16-bit error info word, a 32-bit trap value and a gate that enables the outgoing memory request.

The order is chosen so that a trap handler sees one well-defined fault for each situation. For capability loads and stores the bounds check runs on the raw, possibly unaligned address, so a bounds fault beats a misalignment. An illegal special-register address beats a missing system-register permission and is reported as an illegal instruction.

Top module: `cap_fault_prio`

## Requirements
- R1: While reset is high, every output is zero: valid, fault, exception cause, info word, trap value and request gate.
- R2: An operation presented with `in_valid` high produces `out_vld` high on the next cycle. With `in_valid` low, the next cycle shows `out_vld` and `out_fault` low. Operation class codes are 1 cap load, 2 cap store, 3 jump-and-link, 4 register jump, 5 seal, 6 unseal, 7 special register, and 0 none (never faults).
- R3: For cap loads and stores, bounds are violated when the address is below the first operand's base, or when address+8 is above its top. Address+8 equal to the top is legal. A violation is reported with the capability cause (parameter, default 28) and capability sub-cause 0x01.
- R4: For cap loads and stores, a bounds violation on an unaligned address is reported as a bounds fault, not as a misalignment.
- R5: For both jump classes, the target and the first operand's top have bit 0 cleared before comparison. A target at or above the top, or below the base, is a bounds violation.
- R6: For seal and unseal, the address is checked against the second operand's bounds. An address equal to that top, above it, or below that base is a violation.
- R7: In debug mode no bounds violation is reported for any class.
- R8: For all classes except the special-register class, a nonzero upstream permission cause outranks bounds, store-local and alignment faults, and is reported as the capability cause with that sub-cause.
- R9: For cap stores outside debug mode, a store-local violation (sub-cause 0x16) outranks misalignment. In debug mode the store-local flag is ignored, and an alignment fault is still reported.
- R10: A misalignment with no higher fault is reported with cause 4 for loads, 6 for stores and 0 for jumps. The trap value is the effective address, and the info word is zero.
- R11: For the special-register class, an illegal address outranks a missing system-register permission. It is reported with cause 2, info word 0x1000 and trap value 0.
- R12: A capability fault packs the info word as bit 10 set, register index in bits 9:5 and sub-cause in bits 4:0. The trap value is the low 11 bits of that word, zero-extended. A missing system-register permission uses sub-cause 0x18.
- R13: `req_en` is high exactly when the previous cycle accepted an operation that produced no fault.
- R14: The top bound is 33 bits wide, so a top of 2^32 admits a capability access at 0xFFFFFFF8 and rejects one at 0xFFFFFFF9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_cls | input | 3 | Operation class code (see R2) |
| eff_addr | input | 32 | Effective address or target |
| a_base | input | 32 | First operand base |
| a_top | input | 33 | First operand top |
| b_base | input | 32 | Second operand base |
| b_top | input | 33 | Second operand top |
| perm_cause | input | 5 | Pending upstream capability sub-cause, 0 if none |
| align_vio | input | 1 | Address or target misaligned |
| slc_vio | input | 1 | Store-local violation |
| sysreg_vio | input | 1 | Missing system-register permission |
| illegal_sreg | input | 1 | Illegal special-register address |
| debug_mode | input | 1 | Core in debug mode |
| reg_idx | input | 5 | Register index recorded in the info word |
| out_vld | output | 1 | Verdict valid |
| out_fault | output | 1 | Verdict is a fault |
| out_exc | output | 6 | Exception cause code |
| out_info | output | 16 | Packed error info word |
| out_tval | output | 32 | Trap value |
| req_en | output | 1 | Memory request gate |

## Verification
The embedded assertions check these relations on every cycle:

- valid follows the accepted input by one cycle;
- a fault always closes the request gate;
- an illegal-address verdict always carries the fixed info word and a zero trap value;
- a capability trap value always equals the low bits of its info word;
- an illegal special-register address always wins;
- debug mode never yields a bounds fault on a clean load.

The exact arithmetic edges can only be shown by the bench scenarios: address+8 equal to the top, a top of 2^32, the bit-0 clearing on jumps, and equality with the seal top. The same holds for the choice of the winning cause when several faults meet: bounds against misalignment, store-local against alignment in and out of debug mode, and permission against bounds.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    localparam int XLEN = 32;
    localparam int TW   = XLEN + 1;
    localparam int CCW  = 5;
    localparam int EXW  = 6;
    localparam int IFW  = 16;
    localparam int TVB  = 11;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_CLOAD  = 3'd1,
        OP_CSTORE = 3'd2,
        OP_JAL    = 3'd3,
        OP_JALR   = 3'd4,
        OP_SEAL   = 3'd5,
        OP_UNSEAL = 3'd6,
        OP_SREG   = 3'd7
    } op_e;

    localparam logic [EXW-1:0] EXC_FETCH_MIS = 6'd0;
    localparam logic [EXW-1:0] EXC_ILLEGAL   = 6'd2;
    localparam logic [EXW-1:0] EXC_LOAD_MIS  = 6'd4;
    localparam logic [EXW-1:0] EXC_STORE_MIS = 6'd6;

    localparam logic [CCW-1:0] CC_BOUNDS = 5'h01;
    localparam logic [CCW-1:0] CC_SLC    = 5'h16;
    localparam logic [CCW-1:0] CC_SYSREG = 5'h18;

    localparam logic [IFW-1:0] INFO_ILLEGAL = 16'h1000;

    typedef struct packed {
        logic            fault;
        logic [EXW-1:0]  exc;
        logic [IFW-1:0]  info;
        logic [XLEN-1:0] tval;
    } verdict_t;

    function automatic logic is_capmem(op_e op);
        return (op == OP_CLOAD) || (op == OP_CSTORE);
    endfunction

    function automatic logic is_jump(op_e op);
        return (op == OP_JAL) || (op == OP_JALR);
    endfunction

    function automatic logic [IFW-1:0] pack_cap(logic [4:0] idx, logic [CCW-1:0] cc);
        return {5'h0, 1'b1, idx, cc};
    endfunction

endpackage

// File: rtl/cfp_bounds.sv
module cfp_bounds
    import cfp_pkg::*;
#(
    parameter int CAP_BYTES = 8
) (
    input  op_e              op,
    input  logic [XLEN-1:0]  eff_addr,
    input  logic [XLEN-1:0]  a_base,
    input  logic [TW-1:0]    a_top,
    input  logic [XLEN-1:0]  b_base,
    input  logic [TW-1:0]    b_top,
    input  logic             debug_mode,
    output logic             bound_vio
);
    logic [XLEN-1:0] lo_chk;
    logic [TW-1:0]   hi_chk;
    logic [XLEN-1:0] lim_lo;
    logic [TW-1:0]   lim_hi;
    logic            eq_bad;
    logic            active;

    always_comb begin
        lo_chk = eff_addr;
        hi_chk = {1'b0, eff_addr};
        lim_lo = a_base;
        lim_hi = a_top;
        eq_bad = 1'b0;
        active = 1'b0;
        unique case (op)
            OP_CLOAD, OP_CSTORE: begin
                // raw address, no alignment rounding
                hi_chk = {1'b0, eff_addr} + TW'(CAP_BYTES);
                active = 1'b1;
            end
            OP_JAL, OP_JALR: begin
                lo_chk = {eff_addr[XLEN-1:1], 1'b0};
                hi_chk = {1'b0, eff_addr[XLEN-1:1], 1'b0};
                lim_hi = {a_top[TW-1:1], 1'b0};
                eq_bad = 1'b1;
                active = 1'b1;
            end
            OP_SEAL, OP_UNSEAL: begin
                lim_lo = b_base;
                lim_hi = b_top;
                eq_bad = 1'b1;
                active = 1'b1;
            end
            default: active = 1'b0;
        endcase
        bound_vio = active && !debug_mode &&
                    ((hi_chk > lim_hi) || (lo_chk < lim_lo) ||
                     (eq_bad && (hi_chk == lim_hi)));
    end
endmodule

// File: rtl/cfp_rank.sv
module cfp_rank
    import cfp_pkg::*;
#(
    parameter int CAP_EXC = 28
) (
    input  op_e              op,
    input  logic             bound_vio,
    input  logic [CCW-1:0]   perm_cause,
    input  logic             align_vio,
    input  logic             slc_vio,
    input  logic             sysreg_vio,
    input  logic             illegal_sreg,
    input  logic             debug_mode,
    input  logic [4:0]       reg_idx,
    input  logic [XLEN-1:0]  eff_addr,
    output verdict_t         verdict
);
    localparam logic [EXW-1:0] EXC_CAP = EXW'(CAP_EXC);

    function automatic verdict_t cap_fault(logic [4:0] idx, logic [CCW-1:0] cc);
        verdict_t r;
        r.fault = 1'b1;
        r.exc   = EXC_CAP;
        r.info  = pack_cap(idx, cc);
        r.tval  = {{(XLEN-TVB){1'b0}}, r.info[TVB-1:0]};
        return r;
    endfunction

    function automatic verdict_t mis_fault(logic [EXW-1:0] code, logic [XLEN-1:0] addr);
        verdict_t r;
        r.fault = 1'b1;
        r.exc   = code;
        r.info  = '0;
        r.tval  = addr;
        return r;
    endfunction

    logic perm_hit;
    logic slc_hit;

    assign perm_hit = (perm_cause != '0);
    assign slc_hit  = (op == OP_CSTORE) && slc_vio && !debug_mode;

    always_comb begin
        verdict = '0;
        if (op == OP_SREG) begin
            if (illegal_sreg) begin
                verdict.fault = 1'b1;
                verdict.exc   = EXC_ILLEGAL;
                verdict.info  = INFO_ILLEGAL;
                verdict.tval  = '0;
            end else if (sysreg_vio) begin
                verdict = cap_fault(reg_idx, CC_SYSREG);
            end
        end else if (op != OP_NONE) begin
            if (perm_hit)
                verdict = cap_fault(reg_idx, perm_cause);
            else if (bound_vio)
                verdict = cap_fault(reg_idx, CC_BOUNDS);
            else if (slc_hit)
                verdict = cap_fault(reg_idx, CC_SLC);
            else if (align_vio && is_capmem(op))
                verdict = mis_fault((op == OP_CLOAD) ? EXC_LOAD_MIS : EXC_STORE_MIS, eff_addr);
            else if (align_vio && is_jump(op))
                verdict = mis_fault(EXC_FETCH_MIS, eff_addr);
        end
    end
endmodule

// File: rtl/cap_fault_prio.sv
module cap_fault_prio
    import cfp_pkg::*;
#(
    parameter int CAP_EXC   = 28,
    parameter int CAP_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_cls,
    input  logic [XLEN-1:0]   eff_addr,
    input  logic [XLEN-1:0]   a_base,
    input  logic [TW-1:0]     a_top,
    input  logic [XLEN-1:0]   b_base,
    input  logic [TW-1:0]     b_top,
    input  logic [CCW-1:0]    perm_cause,
    input  logic              align_vio,
    input  logic              slc_vio,
    input  logic              sysreg_vio,
    input  logic              illegal_sreg,
    input  logic              debug_mode,
    input  logic [4:0]        reg_idx,
    output logic              out_vld,
    output logic              out_fault,
    output logic [EXW-1:0]    out_exc,
    output logic [IFW-1:0]    out_info,
    output logic [XLEN-1:0]   out_tval,
    output logic              req_en
);
    localparam logic [EXW-1:0] EXC_CAP = EXW'(CAP_EXC);

    op_e      op;
    logic     bvio;
    verdict_t vd;
    verdict_t vd_q;
    logic     vld_q;
    logic     armed;

    assign op = op_e'(op_cls);

    cfp_bounds #(.CAP_BYTES(CAP_BYTES)) u_bounds (
        .op(op), .eff_addr(eff_addr), .a_base(a_base), .a_top(a_top),
        .b_base(b_base), .b_top(b_top), .debug_mode(debug_mode),
        .bound_vio(bvio)
    );

    cfp_rank #(.CAP_EXC(CAP_EXC)) u_rank (
        .op(op), .bound_vio(bvio), .perm_cause(perm_cause),
        .align_vio(align_vio), .slc_vio(slc_vio), .sysreg_vio(sysreg_vio),
        .illegal_sreg(illegal_sreg), .debug_mode(debug_mode),
        .reg_idx(reg_idx), .eff_addr(eff_addr), .verdict(vd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            vd_q  <= '0;
            armed <= 1'b0;
        end else begin
            vld_q <= in_valid;
            vd_q  <= in_valid ? vd : '0;
            armed <= 1'b1;
        end
    end

    assign out_vld   = vld_q;
    assign out_fault = vd_q.fault;
    assign out_exc   = vd_q.exc;
    assign out_info  = vd_q.info;
    assign out_tval  = vd_q.tval;
    assign req_en    = vld_q && !vd_q.fault;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_vld == $past(in_valid)));

    a_r2_idle_clean: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> !out_fault);

    a_r13_gate_closed: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> !req_en);

    a_r11_illegal_word: assert property (@(posedge clk) disable iff (rst)
        (out_fault && out_exc == EXC_ILLEGAL) |-> (out_info == INFO_ILLEGAL && out_tval == '0));

    a_r11_illegal_wins: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(in_valid && op_cls == 3'd7 && illegal_sreg))
        |-> (out_fault && out_exc == EXC_ILLEGAL));

    a_r12_tval_pack: assert property (@(posedge clk) disable iff (rst)
        (out_fault && out_exc == EXC_CAP)
        |-> (out_info[10] && out_tval == {{(XLEN-TVB){1'b0}}, out_info[TVB-1:0]}));

    a_r7_debug_no_bounds: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(in_valid && debug_mode && perm_cause == '0 && !align_vio
                        && op_cls == 3'd1))
        |-> !out_fault);
endmodule

// File: tb/cap_fault_prio_tb.sv
module cap_fault_prio_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_cls;
    logic [31:0] eff_addr, a_base, b_base;
    logic [32:0] a_top, b_top;
    logic [4:0]  perm_cause, reg_idx;
    logic        align_vio, slc_vio, sysreg_vio, illegal_sreg, debug_mode;
    logic        out_vld, out_fault, req_en;
    logic [5:0]  out_exc;
    logic [15:0] out_info;
    logic [31:0] out_tval;

    always #5 clk = ~clk;

    cap_fault_prio u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_cls(op_cls),
        .eff_addr(eff_addr), .a_base(a_base), .a_top(a_top),
        .b_base(b_base), .b_top(b_top), .perm_cause(perm_cause),
        .align_vio(align_vio), .slc_vio(slc_vio), .sysreg_vio(sysreg_vio),
        .illegal_sreg(illegal_sreg), .debug_mode(debug_mode), .reg_idx(reg_idx),
        .out_vld(out_vld), .out_fault(out_fault), .out_exc(out_exc),
        .out_info(out_info), .out_tval(out_tval), .req_en(req_en)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // expected outputs for the next sample
    bit        e_vld, e_fault, e_req;
    int        e_exc;
    longint    e_info, e_tval;
    string     e_tag;

    task automatic compare();
        n_chk++;
        if (out_vld !== e_vld || out_fault !== e_fault || req_en !== e_req ||
            int'(out_exc) != e_exc || longint'(out_info) != e_info ||
            longint'(out_tval) != e_tval) begin
            n_bad++;
            $display("FAIL %s: got vld=%0d flt=%0d exc=%0d info=%h tval=%h req=%0d ; want vld=%0d flt=%0d exc=%0d info=%h tval=%h req=%0d",
                     e_tag, out_vld, out_fault, out_exc, out_info, out_tval, req_en,
                     e_vld, e_fault, e_exc, e_info[15:0], e_tval[31:0], e_req);
        end
    endtask

    // behavioural reference from the requirement text
    task automatic model(string tag);
        longint e = eff_addr, lo, hi, t, tp;
        bit bv = 0;
        int op = op_cls;
        e_tag = tag;
        e_vld = in_valid; e_fault = 0; e_exc = 0; e_info = 0; e_tval = 0;
        if (op == 1 || op == 2)
            bv = (e < a_base) || (e + 8 > a_top);
        else if (op == 3 || op == 4) begin
            t = e - (e % 2); tp = a_top - (a_top % 2);
            bv = (t < a_base) || (t >= tp);
        end else if (op == 5 || op == 6)
            bv = (e < b_base) || (e >= b_top);
        if (debug_mode) bv = 0;
        lo = 0; hi = 0;
        if (in_valid && op == 7) begin
            if (illegal_sreg) begin e_fault = 1; e_exc = 2; e_info = 4096; end
            else if (sysreg_vio) begin lo = 1; hi = 24; end
        end else if (in_valid && op != 0) begin
            if (perm_cause != 0) begin lo = 1; hi = perm_cause; end
            else if (bv) begin lo = 1; hi = 1; end
            else if (op == 2 && slc_vio && !debug_mode) begin lo = 1; hi = 22; end
            else if (align_vio && op <= 4) begin
                e_fault = 1; e_tval = e;
                e_exc = (op == 1) ? 4 : (op == 2) ? 6 : 0;
            end
        end
        if (lo == 1) begin
            e_fault = 1; e_exc = 28;
            e_info = 1024 + longint'(reg_idx) * 32 + hi;
            e_tval = e_info % 2048;
        end
        e_req = e_vld && !e_fault;
    endtask

    task automatic clear_in();
        in_valid = 0; op_cls = 0; eff_addr = 0; a_base = 0; a_top = 0;
        b_base = 0; b_top = 0; perm_cause = 0; reg_idx = 0; align_vio = 0;
        slc_vio = 0; sysreg_vio = 0; illegal_sreg = 0; debug_mode = 0;
    endtask

    // drive one op at negedge, check it at the following negedge
    task automatic go(string tag, int op, longint ea, longint ab, longint at,
                      longint bb, longint bt, int pc, bit al, bit sl, bit sr,
                      bit il, bit dbg, int idx);
        @(negedge clk);
        compare();
        in_valid = 1; op_cls = 3'(op); eff_addr = 32'(ea); a_base = 32'(ab);
        a_top = 33'(at); b_base = 32'(bb); b_top = 33'(bt);
        perm_cause = 5'(pc); align_vio = al; slc_vio = sl; sysreg_vio = sr;
        illegal_sreg = il; debug_mode = dbg; reg_idx = 5'(idx);
        model(tag);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        compare();
        clear_in();
        model(tag);
    endtask

    initial begin
        clear_in();
        rst = 1;
        e_vld = 0; e_fault = 0; e_req = 0; e_exc = 0; e_info = 0; e_tval = 0;
        e_tag = "R1 reset";
        repeat (3) @(negedge clk);
        compare();
        compare();
        rst = 0;
        model("R2 idle");
        idle("R2 idle after reset");
        go("R2 clean load", 1, 'h1000, 'h1000, 'h1010, 0, 0, 0, 0, 0, 0, 0, 0, 3);
        idle("R2 idle");
        go("R3 top exactly reached", 1, 'h1008, 'h1000, 'h1010, 0, 0, 0, 0, 0, 0, 0, 0, 4);
        go("R3 over top", 2, 'h1009, 'h1000, 'h1010, 0, 0, 0, 0, 0, 0, 0, 0, 5);
        go("R3 below base", 1, 'h0FFF, 'h1000, 'h1010, 0, 0, 0, 0, 0, 0, 0, 0, 6);
        go("R14 top 2^32 fits", 1, 'hFFFF_FFF8, 'hFFFF_0000, 'h1_0000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        go("R14 top 2^32 over", 1, 'hFFFF_FFF9, 'hFFFF_0000, 'h1_0000_0000, 0, 0, 0, 1, 0, 0, 0, 0, 1);
        go("R4 bounds beats misalign", 1, 'h100B, 'h1000, 'h1010, 0, 0, 0, 1, 0, 0, 0, 0, 7);
        go("R10 load misaligned", 1, 'h1003, 'h1000, 'h1010, 0, 0, 0, 1, 0, 0, 0, 0, 7);
        go("R10 store misaligned", 2, 'h1005, 'h1000, 'h1010, 0, 0, 0, 1, 0, 0, 0, 0, 7);
        go("R5 jalr below top", 4, 'h1FFF, 'h1000, 'h2001, 0, 0, 0, 0, 0, 0, 0, 0, 2);
        go("R5 jalr at cleared top", 4, 'h2000, 'h1000, 'h2001, 0, 0, 0, 0, 0, 0, 0, 0, 2);
        go("R5 jal below base", 3, 'h0FFE, 'h1000, 'h2000, 0, 0, 0, 0, 0, 0, 0, 0, 2);
        go("R10 jump misaligned", 3, 'h1802, 'h1000, 'h2000, 0, 0, 0, 1, 0, 0, 0, 0, 2);
        go("R10 jump bounds over align", 4, 'h2002, 'h1000, 'h2000, 0, 0, 0, 1, 0, 0, 0, 0, 2);
        go("R6 seal equal top", 5, 'h40, 0, 0, 'h10, 'h40, 0, 0, 0, 0, 0, 0, 8);
        go("R6 seal inside b", 6, 'h3F, 0, 0, 'h10, 'h40, 0, 0, 0, 0, 0, 0, 8);
        go("R6 unseal below b", 6, 'h0F, 'h0, 'h100, 'h10, 'h40, 0, 0, 0, 0, 0, 0, 8);
        go("R7 debug masks bounds", 1, 'h5000, 'h1000, 'h1010, 0, 0, 0, 0, 0, 0, 0, 1, 9);
        go("R7 debug seal", 5, 'h90, 0, 0, 'h10, 'h40, 0, 0, 0, 0, 0, 1, 9);
        go("R8 perm beats bounds", 2, 'h5000, 'h1000, 'h1010, 0, 0, 2, 1, 1, 0, 0, 0, 10);
        go("R8 perm on jump", 4, 'h1100, 'h1000, 'h2000, 0, 0, 3, 0, 0, 0, 0, 0, 11);
        go("R9 store-local beats align", 2, 'h1001, 'h1000, 'h1010, 0, 0, 0, 1, 1, 0, 0, 0, 12);
        go("R9 debug align not hidden", 2, 'h1001, 'h1000, 'h1010, 0, 0, 0, 1, 1, 0, 0, 1, 12);
        go("R9 store-local on load ignored", 1, 'h1000, 'h1000, 'h1010, 0, 0, 0, 0, 1, 0, 0, 0, 12);
        go("R11 illegal beats perm", 7, 'h55, 0, 0, 0, 0, 4, 0, 0, 1, 1, 0, 13);
        go("R12 sysreg perm packing", 7, 'h55, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 31);
        go("R13 clean sreg", 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        go("R2 none class", 0, 'h5000, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            longint ab = longint'($urandom) & 'hFFFF_FF00;
            longint at = ab + ($urandom % 64);
            longint ea = ab - 8 + ($urandom % 80);
            go("R13 mixed", int'($urandom % 8), ea & 'hFFFF_FFFF, ab, at,
               ab + 16, ab + 16 + ($urandom % 32),
               ($urandom % 4 == 0) ? int'($urandom % 32) : 0,
               1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 3 == 0), ($urandom % 5 == 0), int'($urandom % 32));
            if (i % 7 == 0) idle("R2 idle gap");
        end
        idle("R2 final idle");
        @(negedge clk);
        compare();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule